// File: doc/BRIEF.md
# Reconfigurable Spiking Neuron Grid

A rectangular grid of identical integrate-and-fire neuron cells, 8 by 8 by default. All cells run in lockstep under one shared step controller. A network update takes a fixed 27 clocks, however large the grid is. During one update each cell first samples its own external input. It then visits, one per clock, the 25 positions of the 5×5 window centred on itself, its own position included. On the last clock it decides whether to fire.

Every cell is wired at design time to its whole window. A per-cell function register picks the connection pattern the cell actually uses and whether its spikes are excitatory or inhibitory. A host writes these registers through row and column addresses, a write strobe and a data word. The host starts and pauses the grid with `run`, clears it with `rst`, drives one external spike line per cell and watches every cell's spike output. A `step_done` flag marks the last clock of each update, so the host can count updates or sample the outputs.

Top module: `snn_cell_array`

## Requirements
- R1: While `rst` is high on a clock edge, every potential, spike output, refractory flag, active function, function register and step position returns to zero. After that edge `spike_out` is all zero and `step_done` is low.
- R2: While `run` is high, one update takes exactly 27 clocks. The grid size does not change this. `step_done` is high only on the 27th clock of an update and only while `run` is high, and two clocks in a row never both show it.
- R3: While `run` is low, the step position, every potential, every refractory flag and every spike output hold their values. Configuration writes are still accepted.
- R4: A clock with `cfg_we` high writes `cfg_data` into the function register of cell (`cfg_row`, `cfg_col`). The bit index of that cell in `ext_spike` and `spike_out` is row*COLS+col. In the function word, bits [2:0] select the pattern and bit 3 set makes the cell inhibitory.
- R5: A cell copies its function register into its active function on the final clock of each update, reading the value held before that clock's write. A write made anywhere inside an update therefore takes effect from the next update. A write made on the final clock waits one update more.
- R6: On the first clock of an update, a cell whose `ext_spike` bit is high adds +10 to its potential.
- R7: On clock k+1 of an update (k = 0..24), a cell looks at window position k, at row offset k/5−2 and column offset k%5−2. If that position is in the cell's pattern and its cell spiked in the previous update, the cell adds +2 when the neighbour is excitatory and −2 when it is inhibitory.
- R8: The pattern codes work on the 5×5 window. Code 0 selects nothing, so only the external input counts. Code 1 selects the four orthogonal neighbours. Code 2 selects the eight cells at Chebyshev distance 1. Code 3 selects the sixteen cells at distance 2. Code 4 selects all 24 cells other than itself. Code 5 selects all 25 positions, self included. Codes 6 and 7 behave like code 0.
- R9: On the final clock, a potential of 4 or more makes the cell spike for the following update and resets the potential to 0. During the next update the cell integrates nothing.
- R10: On the final clock, a cell that does not fire drops its potential by 1, and any result below zero becomes zero.
- R11: A window position outside the grid never contributes a spike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the whole grid |
| run | input | 1 | High to advance the update sequence, low to pause |
| cfg_we | input | 1 | Function register write strobe |
| cfg_row | input | RW | Row of the function register to write |
| cfg_col | input | CW | Column of the function register to write |
| cfg_data | input | 4 | Function word: [2:0] pattern, [3] inhibitory |
| ext_spike | input | ROWS*COLS | External spike input per cell, sampled on the first clock of an update |
| spike_out | output | ROWS*COLS | Registered spike output per cell, changes only after the final clock |
| step_done | output | 1 | High on the final clock of an update |

## Verification
The hardest case to reach from the ports is a configuration write that lands mid-update, or on the very final clock, of an update whose outcome depends on that cell's pattern or sign. The write timing decides whether the old or the new function governs the next update. The stimulus first brings a grid of configured drivers to a known firing rhythm through external spikes. It then issues writes at chosen step positions while the grid runs, including the final clock. Pauses in the middle of an update are mixed in. A behavioural model of the whole grid predicts every spike on every clock, and short hand-worked sequences check a single ring-pattern receiver fed by excitatory and then mixed-sign drivers.

// File: rtl/snn_pkg.sv
package snn_pkg;
  localparam int WIN      = 5;
  localparam int WIN_R    = 2;
  localparam int NB_CNT   = WIN * WIN;
  localparam int STEP_CLKS = NB_CNT + 2;
  localparam int PH_W     = $clog2(STEP_CLKS);
  localparam int FUNC_W   = 4;
  localparam int THRESH   = 4;
  localparam int W_EXT    = 10;
  localparam int W_NB     = 2;
  localparam int V_W      = 7;

  typedef logic [PH_W-1:0] phase_t;

  // Pattern selection over the 5x5 window, index k = row*5 + col of window
  function automatic logic [NB_CNT-1:0] pattern_mask(input logic [2:0] pat);
    logic [NB_CNT-1:0] m;
    int dr, dc, adr, adc, cheb;
    m = '0;
    for (int k = 0; k < NB_CNT; k++) begin
      dr   = k / WIN - WIN_R;
      dc   = k % WIN - WIN_R;
      adr  = (dr < 0) ? -dr : dr;
      adc  = (dc < 0) ? -dc : dc;
      cheb = (adr > adc) ? adr : adc;
      case (pat)
        3'd1:    m[k] = ((adr + adc) == 1);
        3'd2:    m[k] = (cheb == 1);
        3'd3:    m[k] = (cheb == 2);
        3'd4:    m[k] = (cheb != 0);
        3'd5:    m[k] = 1'b1;
        default: m[k] = 1'b0;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/snn_step_ctrl.sv
module snn_step_ctrl
  import snn_pkg::*;
#(
  parameter int STEPS = STEP_CLKS
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  output phase_t phase,
  output logic   last
);
  localparam phase_t LAST_PH = phase_t'(STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (run)
      phase <= (phase == LAST_PH) ? '0 : phase + 1'b1;
  end

  assign last = run && (phase == LAST_PH);
endmodule

// File: rtl/snn_cfg_layer.sv
module snn_cfg_layer #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int FW   = 4,
  parameter int RW   = 3,
  parameter int CW   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [RW-1:0]          row,
  input  logic [CW-1:0]          col,
  input  logic [FW-1:0]          din,
  output logic [ROWS*COLS*FW-1:0] cfg_flat
);
  logic [ROWS-1:0] row_hit;
  logic [COLS-1:0] col_hit;

  always_comb begin
    for (int r = 0; r < ROWS; r++) row_hit[r] = (row == RW'(r));
    for (int c = 0; c < COLS; c++) col_hit[c] = (col == CW'(c));
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic [FW-1:0] fn_q;
      always_ff @(posedge clk) begin
        if (rst)
          fn_q <= '0;
        else if (we && row_hit[r] && col_hit[c])
          fn_q <= din;
      end
      assign cfg_flat[IDX*FW +: FW] = fn_q;
    end
  end
endmodule

// File: rtl/snn_cell.sv
module snn_cell
  import snn_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  phase_t            phase,
  input  logic              last,
  input  logic              ext_in,
  input  logic [NB_CNT-1:0] nb_spike,
  input  logic [NB_CNT-1:0] nb_sign,
  input  logic [FUNC_W-1:0] func_in,
  output logic              spike_o,
  output logic              sign_o
);
  localparam logic signed [V_W-1:0] TH_V   = V_W'(THRESH);
  localparam logic signed [V_W-1:0] WEXT_V = V_W'(W_EXT);
  localparam logic signed [V_W-1:0] WNB_V  = V_W'(W_NB);

  logic [FUNC_W-1:0]       func_q;
  logic signed [V_W-1:0]   v_q;
  logic                    refr_q;
  logic                    spike_q;
  logic [NB_CNT-1:0]       eff_s, sh_s, sh_g;
  phase_t                  nb_idx;
  logic                    in_nb;
  logic signed [V_W-1:0]   addend;

  assign nb_idx = phase - 1'b1;
  assign in_nb  = (phase != '0) && (phase <= phase_t'(NB_CNT));

  always_comb begin
    eff_s  = pattern_mask(func_q[2:0]) & nb_spike;
    sh_s   = eff_s >> nb_idx;
    sh_g   = nb_sign >> nb_idx;
    addend = '0;
    if (phase == '0) begin
      if (ext_in) addend = WEXT_V;
    end else if (in_nb && sh_s[0]) begin
      addend = sh_g[0] ? -WNB_V : WNB_V;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q  <= '0;
      v_q     <= '0;
      refr_q  <= 1'b0;
      spike_q <= 1'b0;
    end else if (en) begin
      if (last) begin
        func_q <= func_in;
        if (v_q >= TH_V) begin
          spike_q <= 1'b1;
          v_q     <= '0;
          refr_q  <= 1'b1;
        end else begin
          spike_q <= 1'b0;
          refr_q  <= 1'b0;
          v_q     <= (v_q > 1) ? v_q - 1'sd1 : '0;
        end
      end else if (!refr_q) begin
        v_q <= v_q + addend;
      end
    end
  end

  assign spike_o = spike_q;
  assign sign_o  = func_q[FUNC_W-1];
endmodule

// File: rtl/snn_cell_array.sv
module snn_cell_array
  import snn_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int N  = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cfg_we,
  input  logic [RW-1:0]     cfg_row,
  input  logic [CW-1:0]     cfg_col,
  input  logic [FUNC_W-1:0] cfg_data,
  input  logic [N-1:0]      ext_spike,
  output logic [N-1:0]      spike_out,
  output logic              step_done
);
  phase_t              phase;
  logic                last;
  logic [N*FUNC_W-1:0] cfg_flat;
  logic [N-1:0]        spike_w;
  logic [N-1:0]        sign_w;

  snn_step_ctrl #(.STEPS(STEP_CLKS)) u_ctrl (
    .clk(clk), .rst(rst), .run(run), .phase(phase), .last(last)
  );

  snn_cfg_layer #(.ROWS(ROWS), .COLS(COLS), .FW(FUNC_W), .RW(RW), .CW(CW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .row(cfg_row), .col(cfg_col),
    .din(cfg_data), .cfg_flat(cfg_flat)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      localparam int IDX = r * COLS + c;
      logic [NB_CNT-1:0] nb_s, nb_g;

      // Fixed wiring to every window position; off-grid reads quiet and excitatory
      for (genvar k = 0; k < NB_CNT; k++) begin : g_k
        localparam int RR = r + k / WIN - WIN_R;
        localparam int CC = c + k % WIN - WIN_R;
        if (RR >= 0 && RR < ROWS && CC >= 0 && CC < COLS) begin : g_in
          assign nb_s[k] = spike_w[RR*COLS+CC];
          assign nb_g[k] = sign_w[RR*COLS+CC];
        end else begin : g_off
          assign nb_s[k] = 1'b0;
          assign nb_g[k] = 1'b0;
        end
      end

      snn_cell u_cell (
        .clk(clk), .rst(rst), .en(run), .phase(phase), .last(last),
        .ext_in(ext_spike[IDX]), .nb_spike(nb_s), .nb_sign(nb_g),
        .func_in(cfg_flat[IDX*FUNC_W +: FUNC_W]),
        .spike_o(spike_w[IDX]), .sign_o(sign_w[IDX])
      );
    end
  end

  assign spike_out = spike_w;
  assign step_done = last;
endmodule

// File: rtl/snn_cell_array_chk.sv
module snn_cell_array_chk
  import snn_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int N  = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW = (N > 1) ? $clog2(N) + 1 : 2
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              cfg_we,
  input logic [RW-1:0]     cfg_row,
  input logic [CW-1:0]     cfg_col,
  input logic [FUNC_W-1:0] cfg_data,
  input logic [N-1:0]      spike_out,
  input logic              step_done,
  input phase_t            phase,
  input logic [N*FUNC_W-1:0] cfg_flat
);
  logic [AW-1:0]     waddr, waddr_q;
  logic [FUNC_W-1:0] wdata_q;

  assign waddr = AW'(cfg_row) * AW'(COLS) + AW'(cfg_col);

  always_ff @(posedge clk) begin
    waddr_q <= waddr;
    wdata_q <= cfg_data;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (spike_out == '0) && !step_done);

  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
    phase <= phase_t'(STEP_CLKS - 1));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    step_done |=> !step_done);

  assert_done_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
    step_done |-> run);

  assert_pause_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(spike_out) && $stable(phase));

  assert_cfg_write_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (int'(waddr_q) >= N) ||
               (cfg_flat[int'(waddr_q)*FUNC_W +: FUNC_W] == wdata_q));

  assert_spike_at_end_R9: assert property (@(posedge clk) disable iff (rst)
    !step_done |=> $stable(spike_out));
endmodule

bind snn_cell_array snn_cell_array_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_row(cfg_row),
  .cfg_col(cfg_col), .cfg_data(cfg_data), .spike_out(spike_out),
  .step_done(step_done), .phase(phase), .cfg_flat(cfg_flat)
);

// File: tb/snn_cell_array_bench.sv
module snn_cell_array_bench;
  localparam int CLK_P = 10;
  localparam int ROWS  = 8;
  localparam int COLS  = 8;
  localparam int N     = ROWS * COLS;
  localparam int LAST  = 26;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic         rst = 1'b1, run = 1'b0, cfg_we = 1'b0;
  logic [2:0]   cfg_row = '0, cfg_col = '0;
  logic [3:0]   cfg_data = '0;
  logic [N-1:0] ext_spike = '0;
  logic [N-1:0] spike_out;
  logic         step_done;

  snn_cell_array u_snn_cell_array (
    .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_col(cfg_col), .cfg_data(cfg_data), .ext_spike(ext_spike),
    .spike_out(spike_out), .step_done(step_done)
  );

  int    m_v[N];
  bit    m_ref[N];
  bit    m_spk[N];
  int    m_act[N];
  int    m_cfg[N];
  int    m_ph;
  int    vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit    finished = 0;

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic bit in_pat(int pat, int dr, int dc);
    int d1, d2;
    d1 = iabs(dr) + iabs(dc);
    d2 = (iabs(dr) > iabs(dc)) ? iabs(dr) : iabs(dc);
    case (pat)
      1: return d1 == 1;
      2: return d2 == 1;
      3: return d2 == 2;
      4: return d2 != 0;
      5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model_clock();
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_v[i] = 0; m_ref[i] = 0; m_spk[i] = 0; m_act[i] = 0; m_cfg[i] = 0;
      end
      m_ph = 0;
      return;
    end
    if (run) begin
      if (m_ph == 0) begin
        for (int i = 0; i < N; i++)
          if (!m_ref[i] && ext_spike[i]) m_v[i] += 10;
      end else if (m_ph < LAST) begin
        for (int i = 0; i < N; i++) begin
          int dr, dc, rr, cc, j;
          dr = (m_ph - 1) / 5 - 2;
          dc = (m_ph - 1) % 5 - 2;
          rr = i / COLS + dr;
          cc = i % COLS + dc;
          if (!m_ref[i] && rr >= 0 && rr < ROWS && cc >= 0 && cc < COLS &&
              in_pat(m_act[i] % 8, dr, dc)) begin
            j = rr * COLS + cc;
            if (m_spk[j]) m_v[i] += (m_act[j] >= 8) ? -2 : 2;
          end
        end
      end else begin
        for (int i = 0; i < N; i++) begin
          if (m_v[i] >= 4) begin
            m_spk[i] = 1; m_v[i] = 0; m_ref[i] = 1;
          end else begin
            m_spk[i] = 0; m_ref[i] = 0;
            m_v[i] = (m_v[i] > 1) ? m_v[i] - 1 : 0;
          end
          m_act[i] = m_cfg[i];
        end
      end
      m_ph = (m_ph == LAST) ? 0 : m_ph + 1;
    end
    if (cfg_we) m_cfg[cfg_row * COLS + cfg_col] = cfg_data;
  endtask

  task automatic check(bit ok, string what, logic [N-1:0] act, logic [N-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic cycle();
    logic [N-1:0] expv;
    #1;
    if (!rst)
      check(step_done == (run && m_ph == LAST), "step_done",
            N'(step_done), N'(run && m_ph == LAST));
    model_clock();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) expv[i] = m_spk[i];
    check(spike_out == expv, "spike_out", spike_out, expv);
  endtask

  task automatic write_cfg(int r, int c, int d);
    cfg_we = 1; cfg_row = 3'(r); cfg_col = 3'(c); cfg_data = 4'(d);
    cycle();
    cfg_we = 0;
  endtask

  task automatic steps(int n);
    repeat (n * (LAST + 1)) cycle();
  endtask

  task automatic expect_spike(int idx, bit exp);
    check(spike_out[idx] == exp, $sformatf("cell %0d by hand", idx),
          N'(spike_out[idx]), N'(exp));
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset clears everything
    cur_req = "R1";
    rst = 1;
    repeat (3) cycle();
    check(spike_out == '0, "after reset", spike_out, '0);
    rst = 0;

    // R6 R9 R2: isolated cell with constant external input fires every other update
    cur_req = "R6 R9 R2";
    run = 1;
    ext_spike[0] = 1;
    steps(1); expect_spike(0, 1);
    steps(1); expect_spike(0, 0);
    steps(1); expect_spike(0, 1);
    ext_spike = '0;
    steps(2);

    // R8 R4: ring-2 receiver at (3,3) fed by four excitatory drivers
    cur_req = "R8 R4";
    run = 0;
    write_cfg(3, 3, 3);
    write_cfg(3, 5, 0); write_cfg(5, 3, 0); write_cfg(1, 1, 0); write_cfg(3, 1, 0);
    run = 1;
    steps(1);
    ext_spike[3*8+5] = 1; ext_spike[5*8+3] = 1; ext_spike[1*8+1] = 1; ext_spike[3*8+1] = 1;
    steps(1);
    ext_spike = '0;
    steps(1); expect_spike(27, 1);

    // R7: two drivers turned inhibitory cancel the excitation
    cur_req = "R7";
    run = 0;
    write_cfg(3, 5, 8); write_cfg(5, 3, 8);
    run = 1;
    steps(1);
    ext_spike[3*8+5] = 1; ext_spike[5*8+3] = 1; ext_spike[1*8+1] = 1; ext_spike[3*8+1] = 1;
    steps(1);
    ext_spike = '0;
    steps(1); expect_spike(27, 0);
    steps(1);

    // R11 R10: edge and corner cells with wide patterns
    cur_req = "R11 R10";
    run = 0;
    write_cfg(0, 0, 5); write_cfg(0, 7, 4); write_cfg(7, 0, 2); write_cfg(7, 7, 5);
    write_cfg(0, 1, 0); write_cfg(1, 0, 8); write_cfg(6, 7, 0); write_cfg(7, 6, 1);
    run = 1;
    for (int s = 0; s < 20; s++) begin
      for (int i = 0; i < N; i++) ext_spike[i] = ($urandom % 3 == 0);
      steps(1);
    end

    // R3: pause in the middle of an update
    cur_req = "R3";
    repeat (12) cycle();
    run = 0;
    write_cfg(4, 4, 2);
    repeat (6) cycle();
    run = 1;
    repeat (LAST + 1 - 12) cycle();
    steps(2);

    // R5: writes inside an update and on its final clock
    cur_req = "R5";
    for (int s = 0; s < 12; s++) begin
      for (int i = 0; i < N; i++) ext_spike[i] = ($urandom % 2 == 0);
      repeat (3 + s) cycle();
      write_cfg($urandom % 8, $urandom % 8, $urandom % 16);
      while (m_ph != LAST) cycle();
      write_cfg($urandom % 8, $urandom % 8, $urandom % 16);
    end

    // R4 R7 R8 R10: random configuration and inputs
    cur_req = "R4 R7 R8 R10";
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) write_cfg(r, c, $urandom % 16);
    for (int s = 0; s < 150; s++) begin
      for (int i = 0; i < N; i++) ext_spike[i] = ($urandom % 5 == 0);
      if (s % 10 == 0) write_cfg($urandom % 8, $urandom % 8, $urandom % 16);
      steps(1);
    end

    // R1 again: reset in the middle of activity
    cur_req = "R1";
    repeat (5) cycle();
    rst = 1;
    cycle();
    check(spike_out == '0, "mid-run reset", spike_out, '0);
    rst = 0;
    steps(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule